// File: doc/BRIEF.md
# Burst Synchronous Serial Port

This block moves 8-bit bytes over a three-wire clocked serial link (clock, data out, data in) in bursts of one to eight bytes. A host first loads up to eight bytes into a small on-chip buffer through a simple register port. It then issues a single start command that gives the byte count. The port shifts the bytes out one after another with no further host action. Each byte clocked in from the far end overwrites the slot its outgoing byte came from, so once the burst ends the host reads the replies in transmit order.

The serial clock can come from an internal divider or from an external master. In a select-gated mode the clock and data outputs float while the active-low select input is high. Raising select in the middle of a burst aborts it and leaves a count of the bytes that finished.

Top module: `burst_serial_port`

## Requirements
- R1: Register addresses 0 to 7 map to the eight byte slots, which can be written and read back while the port is idle. Address 8 is the control register on write and the status register on read. Status layout: bit 7 is busy, bit 6 is the abort flag, bits 3:0 are the completed byte count.
- R2: Writing address 8 with bit 7 set starts a burst of (bits 2:0)+1 bytes taken from slots 0 upward. Each byte is sent most significant bit first.
- R3: Outgoing data changes only on falling serial clock edges. Incoming data is sampled on rising edges.
- R4: When the clock is internal, it idles high. Each bit period is 8 system clocks low followed by 8 system clocks high, and bits run back to back across byte boundaries.
- R5: Each received byte is written into the slot of the byte sent in the same period.
- R6: When the last byte completes, `done` is high for exactly one system clock and `busy` falls on that same clock. Status then shows the byte count and a clear abort flag.
- R7: While busy, writes to address 8 (including start) and writes to slots are ignored.
- R8: When control bit 3 is set, the port is driven by the external clock on `sck_in`, which passes through a two-flop synchroniser before edge detection. In this mode `sck_oe` is 0.
- R9: When control bit 4 is set (select mode), `sdo_oe` and `sck_oe` are 0 while the synchronised `cs_n` is high and enabled while it is low. Shifting only advances while select is low.
- R10: In select mode, a rising `cs_n` during a burst aborts it: `busy` falls without a `done` pulse, the abort flag is set, and the count gives the fully completed bytes. The slot of the partial byte keeps its transmit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Internally generated serial clock |
| sck_oe | output | 1 | Output enable for the serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for serial data |
| cs_n | input | 1 | Active-low select |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-clock burst completion pulse |

## Verification
The float check assumes `cs_n` is a clean level and that select mode is not switched while a burst runs. The stimulus only raises or lowers select between register accesses, and sets the mode before starting. The edge-timing properties assume an external clock whose levels each last several system clocks. The stimulus holds each external level for six clocks, which leaves room for the synchroniser delay on both the sampling edge and the launch edge.

// File: rtl/burst_serial_port.sv
module burst_serial_port #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int HALF  = 8,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          sck_in,
  output logic          sck_out,
  output logic          sck_oe,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  input  logic          cs_n,
  output logic          busy,
  output logic          done
);
  localparam int IW   = $clog2(DEPTH);
  localparam int BW   = $clog2(DW);
  localparam int DIVW = $clog2(2*HALF);
  localparam logic [AW-1:0] CTRL = AW'(DEPTH);

  logic [DW-1:0]   mem [DEPTH];
  logic [IW-1:0]   cnt_m1, idx;
  logic [IW:0]     done_cnt;
  logic [BW-1:0]   bitn;
  logic [DW-1:0]   rxs;
  logic [DIVW-1:0] div;
  logic            ext_mode, cs_mode, aborted, sck_r, sdo_r, busy_r, done_r;
  logic [2:0]      sk, cs;

  wire ctrl_wr = reg_we && reg_addr == CTRL && !busy_r;
  wire start   = ctrl_wr && reg_wdata[DW-1];
  wire slot_wr = reg_we && reg_addr < AW'(DEPTH) && !busy_r;
  wire gate    = !cs_mode || !cs[1];
  wire fall_ev = busy_r && gate && (ext_mode ? (sk[2] && !sk[1]) : (div == '0));
  wire rise_ev = busy_r && gate && (ext_mode ? (!sk[2] && sk[1]) : (div == DIVW'(HALF)));
  wire abort   = busy_r && cs_mode && cs[1] && !cs[2];
  wire unused_wbits = ^reg_wdata[DW-2:IW+2];

  assign sck_out = sck_r;
  assign sck_oe  = !ext_mode && gate;
  assign sdo     = sdo_r;
  assign sdo_oe  = gate;
  assign busy    = busy_r;
  assign done    = done_r;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < AW'(DEPTH)) reg_rdata = mem[reg_addr[IW-1:0]];
    else if (reg_addr == CTRL) begin
      reg_rdata[DW-1] = busy_r;
      reg_rdata[DW-2] = aborted;
      reg_rdata[IW:0] = done_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sk <= '1;
      cs <= '1;
    end else begin
      sk <= {sk[1:0], sck_in};
      cs <= {cs[1:0], cs_n};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      cnt_m1 <= '0; idx <= '0; done_cnt <= '0; bitn <= '0; rxs <= '0; div <= '0;
      ext_mode <= 1'b0; cs_mode <= 1'b0; aborted <= 1'b0;
      sck_r <= 1'b1; sdo_r <= 1'b0; busy_r <= 1'b0; done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (slot_wr) mem[reg_addr[IW-1:0]] <= reg_wdata;
      if (ctrl_wr) begin
        cnt_m1   <= reg_wdata[IW-1:0];
        ext_mode <= reg_wdata[IW];
        cs_mode  <= reg_wdata[IW+1];
      end
      if (start) begin
        busy_r <= 1'b1; idx <= '0; bitn <= '0; div <= '0;
        done_cnt <= '0; aborted <= 1'b0;
      end
      if (busy_r && !ext_mode && gate)
        div <= (div == DIVW'(2*HALF-1)) ? '0 : div + 1'b1;
      if (fall_ev) begin
        sck_r <= 1'b0;
        sdo_r <= mem[idx][(DW-1) - int'(bitn)];
      end
      if (rise_ev) begin
        sck_r <= 1'b1;
        rxs   <= {rxs[DW-2:0], sdi};
        bitn  <= bitn + 1'b1;
        if (bitn == BW'(DW-1)) begin
          mem[idx] <= {rxs[DW-2:0], sdi};
          done_cnt <= {1'b0, idx} + 1'b1;
          if (idx == cnt_m1) begin
            busy_r <= 1'b0;
            done_r <= 1'b1;
          end else idx <= idx + 1'b1;
        end
      end
      if (abort) begin
        busy_r  <= 1'b0;
        aborted <= 1'b1;
        sck_r   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_serial_port_chk.sv
module burst_serial_port_chk #(parameter int IW = 3) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          sck_out,
  input logic          sdo,
  input logic          sdo_oe,
  input logic          cs_n,
  input logic          ext,
  input logic          csm,
  input logic [IW-1:0] cnt_m1
);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r4_sck_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_out);
  a_r3_sdo_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ext && sck_out && $past(sck_out)) |-> $stable(sdo));
  a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cnt_m1));
  a_r9_float: assert property (@(posedge clk) disable iff (!rst_n)
    (csm && $past(cs_n, 2)) |-> !sdo_oe);
endmodule

bind burst_serial_port burst_serial_port_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .sck_out(sck_out),
  .sdo(sdo), .sdo_oe(sdo_oe), .cs_n(cs_n), .ext(ext_mode), .csm(cs_mode),
  .cnt_m1(cnt_m1)
);

// File: tb/burst_serial_port_tb.sv
`timescale 1ns/1ps
module burst_serial_port_tb;
  logic clk = 0, rst_n = 0, reg_we = 0, sck_in = 1, sdi = 0, cs_n = 1;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic sck_out, sck_oe, sdo, sdo_oe, busy, done;

  burst_serial_port u_dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, done_seen = 0;
  logic [7:0] tx_q[$], slv_q[$], rx_q[$];
  logic mon_en = 0, per_en = 0, have_rise = 0;
  logic [2:0] sbit = 0, mbit = 0;
  logic [7:0] scur = 0, mcap = 0;
  int t_fall = 0, t_rise = 0;
  wire sck_line = sck_oe ? sck_out : sck_in;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) if (done) done_seen++;

  always @(negedge sck_line) if (mon_en) begin
    if (sbit == 0) scur = (slv_q.size() != 0) ? slv_q.pop_front() : 8'h00;
    sdi <= scur[7 - sbit];
    sbit = sbit + 1;
  end

  always @(posedge sck_line) if (mon_en) begin
    mcap = {mcap[6:0], sdo};
    mbit = mbit + 1;
    if (mbit == 0) check("R2/R3 sdo byte", mcap, (tx_q.size() != 0) ? tx_q.pop_front() : 'hx);
  end

  always @(posedge sck_line) if (per_en) begin
    check("R4 low phase ns", int'($time) - t_fall, 64);
    t_rise = int'($time); have_rise = 1;
  end
  always @(negedge sck_line) if (per_en) begin
    if (have_rise) check("R4 high phase ns", int'($time) - t_rise, 64);
    t_fall = int'($time);
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic prep(int n, int seed);
    tx_q.delete(); slv_q.delete(); rx_q.delete();
    sbit = 0; mbit = 0; have_rise = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] t, r;
      t = 8'(seed * 37 + i * 91 + 5);
      r = 8'(~(seed * 13 + i * 29));
      wr(4'(i), t);
      tx_q.push_back(t); slv_q.push_back(r); rx_q.push_back(r);
    end
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
  endtask

  task automatic check_slots(int n);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      rd(4'(i), d);
      check("R5 rx in slot", d, rx_q.pop_front());
    end
  endtask

  task automatic run_int(int n, int seed);
    int d0;
    logic [7:0] st;
    prep(n, seed);
    mon_en = 1; per_en = 1; d0 = done_seen;
    wr(4'd8, 8'h80 | 8'(n - 1));
    check("R2 busy after start", busy, 1);
    wait_idle();
    repeat (3) @(negedge clk);
    mon_en = 0; per_en = 0;
    check("R6 one done pulse", done_seen - d0, 1);
    check("R4 sck idles high", sck_out, 1);
    rd(4'd8, st);
    check("R6 status count", st, n);
    check_slots(n);
  endtask

  task automatic run_ext(int n, int seed);
    int d0;
    logic [7:0] st;
    prep(n, seed);
    wr(4'd8, 8'h08 | 8'(n - 1));
    check("R8 sck_oe low", sck_oe, 0);
    mon_en = 1; d0 = done_seen;
    wr(4'd8, 8'h88 | 8'(n - 1));
    repeat (3) @(negedge clk);
    for (int b = 0; b < 8 * n; b++) begin
      sck_in = 0; repeat (6) @(negedge clk);
      sck_in = 1; repeat (6) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    mon_en = 0;
    check("R8 ext burst busy", busy, 0);
    check("R8 ext done pulse", done_seen - d0, 1);
    rd(4'd8, st);
    check("R8 ext status", st, n);
    check_slots(n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [7:0] d;
    int d0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R6 reset busy", busy, 0);
    check("R6 reset done", done, 0);
    check("R4 reset sck", sck_out, 1);
    rd(4'd8, d);
    check("R1 reset status", d, 0);

    wr(4'd3, 8'hC3); rd(4'd3, d);
    check("R1 slot readback", d, 8'hC3);

    run_int(1, 1);
    run_int(8, 2);
    run_int(3, 3);

    // R7: writes while busy are ignored
    wr(4'd5, 8'h5A);
    prep(2, 4);
    mon_en = 1; d0 = done_seen;
    wr(4'd8, 8'h81);
    repeat (20) @(negedge clk);
    wr(4'd8, 8'h87);
    wr(4'd5, 8'hEE);
    wait_idle(); repeat (3) @(negedge clk); mon_en = 0;
    rd(4'd8, d);
    check("R7 count kept", d, 2);
    rd(4'd5, d);
    check("R7 slot write ignored", d, 8'h5A);
    check("R7 single done", done_seen - d0, 1);
    check_slots(2);

    run_ext(3, 5);

    // R9 / R10 select mode and abort
    cs_n = 1;
    wr(4'd8, 8'h12);
    repeat (3) @(negedge clk);
    check("R9 sdo floats", sdo_oe, 0);
    check("R9 sck floats", sck_oe, 0);
    cs_n = 0;
    repeat (3) @(negedge clk);
    check("R9 sdo driven", sdo_oe, 1);
    check("R9 sck driven", sck_oe, 1);
    prep(3, 6);
    mon_en = 1; d0 = done_seen;
    wr(4'd8, 8'h92);
    repeat (200) @(negedge clk);
    mon_en = 0;
    cs_n = 1;
    repeat (5) @(negedge clk);
    check("R10 busy after abort", busy, 0);
    check("R10 no done", done_seen - d0, 0);
    rd(4'd8, d);
    check("R10 status abort+count", d, 8'h41);
    rd(4'd0, d);
    check("R10 slot0 received", d, rx_q[0]);
    rd(4'd1, d);
    check("R10 partial slot kept", d, 8'(6 * 37 + 91 + 5));
    check("R9 floats after abort", sdo_oe, 0);

    summary();
  end
endmodule